// File: doc/BRIEF.md
# TDM Serial Slot Engine

This block moves 8-bit timeslots across a time-division-multiplexed serial line. It runs on a fast engine clock and watches an externally supplied bit clock and frame sync. It detects each rising edge of the bit clock after synchronisation and treats that edge as the start of a bit time. Transmit bytes come from a valid/ready byte source and are shifted out on a data pin with its own output enable. Received bits are sampled at a programmable engine-clock count inside each bit time and are handed to a byte sink as whole bytes.

A frame holds a programmable number of slots of 8 bits each. An optional single spare bit can close the frame. Each slot has its own transmit-enable bit and receive-enable bit. The first frame sync seen after the engine is enabled aligns the slot and bit counters. From then on, every frame sync pulse is checked against the position where it is expected. A sync pulse that is absent, or one that arrives at any other position, stops the engine. The position at which the error was seen stays visible on the position outputs until the engine is disabled.

Top module: `tdm_slot_engine`

## Requirements
- R1: While `enable` is low, `dout_en`, `tx_ready` and `rx_valid` are low, all four error flags read 0, and the position outputs read slot 0, bit 0, spare 0. Bit-clock and sync activity in this state has no effect.
- R2: After enable, nothing is driven and no source byte is taken until the first frame sync. That sync, sampled at a bit-clock rising edge, marks slot 0, bit 0.
- R3: Each driven slot takes one byte from the source at its first bit. With `lsb_first`=0 the bits go out bit 7 first; with `lsb_first`=1 they go out bit 0 first. Each bit is held for one bit time.
- R4: Received bits are sampled when the engine-clock count since the bit-clock edge equals `sample_pt`. They are placed in a byte in the order set by `lsb_first`, and the byte is delivered after its last bit.
- R5: Slot n (counted from 0) is driven only when `tx_mask[n]`=1. A slot with `tx_mask[n]`=0 leaves `dout_en` low and takes no source byte. A slot with `rx_mask[n]`=0 is sampled but delivers nothing.
- R6: In the last bit of a driven slot, `dout_en` falls once the engine-clock count reaches `drive_stop`. It stays high when the following slot is also driven; this includes the wrap from the last slot to slot 0 when there is no spare bit.
- R7: A frame lasts `num_slots`×8 bit times, plus one when `extra_bit`=1. The spare bit is never driven or sampled. With correctly placed syncs, no error flag is raised.
- R8: If no sync is present at the frame-start edge, `err_missed` is set. The engine then stops driving, sampling and taking bytes, and the position outputs hold the frame-start position.
- R9: A sync at any edge other than frame start sets `err_extra` and halts the engine as in R8. The position outputs then hold the slot and bit that began at that edge.
- R10: If a driven slot starts while `tx_valid` is low, `err_underrun` is set and stays set. The slot is driven as all zeros.
- R11: If a byte completes while `rx_valid` is still high and `rx_ready` is low, `err_overflow` is set and stays set. `rx_data` then carries the newest byte.
- R12: `sync_sel`=0 selects `fsync0` and `sync_sel`=1 selects `fsync1`. Pulses on the unselected input are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine run; low clears counters and flags |
| sync_sel | input | 1 | Frame sync input select |
| lsb_first | input | 1 | Bit order select |
| extra_bit | input | 1 | Adds one spare bit at frame end |
| num_slots | input | 10 | Slots per frame, 1 to 512 |
| sample_pt | input | 16 | Sample instant, engine clocks into the bit |
| drive_stop | input | 16 | Drive release instant for a slot's last bit |
| tx_mask | input | 512 | Per-slot transmit enable |
| rx_mask | input | 512 | Per-slot receive enable |
| bclk | input | 1 | Serial bit clock |
| fsync0 | input | 1 | Frame sync, choice 0 |
| fsync1 | input | 1 | Frame sync, choice 1 |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_en | output | 1 | Transmit output enable |
| tx_data | input | 8 | Source byte |
| tx_valid | input | 1 | Source byte available |
| tx_ready | output | 1 | Source byte taken this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Sink accepts byte |
| err_missed | output | 1 | Sticky: expected sync absent |
| err_extra | output | 1 | Sticky: sync out of place |
| err_underrun | output | 1 | Sticky: source empty at slot start |
| err_overflow | output | 1 | Sticky: received byte not taken in time |
| pos_slot | output | 9 | Current or halted slot index |
| pos_bit | output | 3 | Current or halted bit index |
| pos_xbit | output | 1 | Position is the spare bit |

## Verification
A sync error can be detected on the same bit-clock edge at which a driven slot would begin and take its source byte. The missed-sync case provokes this: slot 0 is driven, and the sync is withheld at the start of the second frame. The error must win. The bench judges this by confirming that its own source counter does not advance, that `dout_en` stays low through the bits that follow, and that `err_missed` is set while `err_extra` stays clear.

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine #(
  parameter int MAX_SLOTS = 512,
  parameter int CW        = 16,
  localparam int SW       = $clog2(MAX_SLOTS),
  localparam int NW       = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 sync_sel,
  input  logic                 lsb_first,
  input  logic                 extra_bit,
  input  logic [NW-1:0]        num_slots,
  input  logic [CW-1:0]        sample_pt,
  input  logic [CW-1:0]        drive_stop,
  input  logic [MAX_SLOTS-1:0] tx_mask,
  input  logic [MAX_SLOTS-1:0] rx_mask,
  input  logic                 bclk,
  input  logic                 fsync0,
  input  logic                 fsync1,
  input  logic                 din,
  output logic                 dout,
  output logic                 dout_en,
  input  logic [7:0]           tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [7:0]           rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 err_missed,
  output logic                 err_extra,
  output logic                 err_underrun,
  output logic                 err_overflow,
  output logic [SW-1:0]        pos_slot,
  output logic [2:0]           pos_bit,
  output logic                 pos_xbit
);

  typedef enum logic [1:0] {S_WAIT, S_RUN, S_HALT} st_t;

  logic [2:0]    bclk_sh;
  logic [1:0]    fs0_sh, fs1_sh, din_sh;
  st_t           st_q;
  logic [SW-1:0] slot_q;
  logic [2:0]    bit_q;
  logic          xbit_q;
  logic [CW-1:0] ecnt_q;
  logic [7:0]    tx_byte_q;
  logic [7:0]    rx_sh_q, rx_next;

  wire bit_edge = bclk_sh[1] & ~bclk_sh[2];
  wire fs_now   = sync_sel ? fs1_sh[1] : fs0_sh[1];
  wire din_s    = din_sh[1];
  wire running  = (st_q == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sh <= '0; fs0_sh <= '0; fs1_sh <= '0; din_sh <= '0;
    end else begin
      bclk_sh <= {bclk_sh[1:0], bclk};
      fs0_sh  <= {fs0_sh[0], fsync0};
      fs1_sh  <= {fs1_sh[0], fsync1};
      din_sh  <= {din_sh[0], din};
    end
  end

  logic [SW-1:0] nx_slot;
  logic [2:0]    nx_bit;
  logic          nx_x;
  wire last_slot = ({1'b0, slot_q} == num_slots - NW'(1));

  always_comb begin
    nx_slot = slot_q;
    nx_bit  = bit_q + 3'd1;
    nx_x    = 1'b0;
    if (xbit_q) begin
      nx_slot = '0;
      nx_bit  = '0;
    end else if (bit_q == 3'd7) begin
      nx_bit = '0;
      if (!last_slot)     nx_slot = slot_q + SW'(1);
      else if (extra_bit) nx_x    = 1'b1;
      else                nx_slot = '0;
    end
  end

  wire nx_start = !nx_x && nx_bit == 3'd0 && nx_slot == '0;
  wire align    = enable && st_q == S_WAIT && bit_edge && fs_now;
  wire adv      = enable && running && bit_edge;
  wire missed   = adv && nx_start && !fs_now;
  wire extra    = adv && !nx_start && fs_now;
  wire sync_bad = missed | extra;
  wire enter    = align | (adv & ~sync_bad);

  wire [SW-1:0] ent_slot = align ? '0 : nx_slot;
  wire [2:0]    ent_bit  = align ? '0 : nx_bit;
  wire          ent_x    = align ? 1'b0 : nx_x;

  wire slot_load = enter && ent_bit == 3'd0 && !ent_x && tx_mask[ent_slot];
  assign tx_ready = slot_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_WAIT; slot_q <= '0; bit_q <= '0; xbit_q <= 1'b0; ecnt_q <= '0;
      err_missed <= 1'b0; err_extra <= 1'b0;
    end else if (!enable) begin
      st_q <= S_WAIT; slot_q <= '0; bit_q <= '0; xbit_q <= 1'b0; ecnt_q <= '0;
      err_missed <= 1'b0; err_extra <= 1'b0;
    end else begin
      if (bit_edge)           ecnt_q <= '0;
      else if (ecnt_q != '1)  ecnt_q <= ecnt_q + CW'(1);
      if (enter || sync_bad) begin
        slot_q <= ent_slot;
        bit_q  <= ent_bit;
        xbit_q <= ent_x;
        st_q   <= sync_bad ? S_HALT : S_RUN;
      end
      err_missed <= err_missed | missed;
      err_extra  <= err_extra | extra;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte_q <= '0; err_underrun <= 1'b0;
    end else if (!enable) begin
      tx_byte_q <= '0; err_underrun <= 1'b0;
    end else if (slot_load) begin
      tx_byte_q    <= tx_valid ? tx_data : 8'h00;
      err_underrun <= err_underrun | ~tx_valid;
    end
  end

  wire cur_drv = running && !xbit_q && tx_mask[slot_q];
  wire nxt_drv = !nx_x && tx_mask[nx_slot];
  wire release_last = (bit_q == 3'd7) && !nxt_drv && (ecnt_q >= drive_stop);
  wire [2:0] tx_idx = lsb_first ? bit_q : 3'd7 - bit_q;

  assign dout_en = cur_drv && !release_last;
  assign dout    = dout_en & tx_byte_q[tx_idx];

  wire samp = running && !xbit_q && (ecnt_q == sample_pt);
  wire done = samp && bit_q == 3'd7 && rx_mask[slot_q];

  always_comb begin
    rx_next         = rx_sh_q;
    rx_next[tx_idx] = din_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh_q <= '0; rx_data <= '0; rx_valid <= 1'b0; err_overflow <= 1'b0;
    end else if (!enable) begin
      rx_sh_q <= '0; rx_data <= '0; rx_valid <= 1'b0; err_overflow <= 1'b0;
    end else begin
      if (samp) rx_sh_q <= rx_next;
      if (done) begin
        rx_data      <= rx_next;
        rx_valid     <= 1'b1;
        err_overflow <= err_overflow | (rx_valid & ~rx_ready);
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assign pos_slot = slot_q;
  assign pos_bit  = bit_q;
  assign pos_xbit = xbit_q;

endmodule

// File: rtl/tdm_slot_engine_chk.sv
module tdm_slot_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       dout_en,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       err_missed,
  input logic       err_extra,
  input logic       err_underrun,
  input logic       err_overflow,
  input logic [2:0] pos_bit,
  input logic       pos_xbit
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!dout_en && !tx_ready && !rx_valid));

  p_pop_at_slot_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (pos_bit == 3'd0 && !pos_xbit));

  p_halt_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_missed || err_extra) |-> (!dout_en && !tx_ready));

  p_single_sync_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_missed && err_extra));

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underrun && enable) |=> err_underrun);

  p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow && enable) |=> err_overflow);

  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && enable) |=> rx_valid);

endmodule

bind tdm_slot_engine tdm_slot_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .dout_en(dout_en),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .err_missed(err_missed), .err_extra(err_extra),
  .err_underrun(err_underrun), .err_overflow(err_overflow),
  .pos_bit(pos_bit), .pos_xbit(pos_xbit)
);

// File: tb/tb_tdm_slot_engine.sv
module tb_tdm_slot_engine;
  localparam int MS = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, enable = 1'b0, sync_sel = 1'b0;
  logic          lsb_first = 1'b0, extra_bit = 1'b0;
  logic [9:0]    num_slots = 10'd4;
  logic [15:0]   sample_pt = 16'd6, drive_stop = 16'd12;
  logic [MS-1:0] tx_mask = '0, rx_mask = '0;
  logic          bclk = 1'b0, fsync0 = 1'b0, fsync1 = 1'b0, din = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_valid;
  logic          rx_ready = 1'b1;
  logic          dout, dout_en, tx_ready, rx_valid;
  logic [7:0]    rx_data;
  logic          err_missed, err_extra, err_underrun, err_overflow;
  logic [8:0]    pos_slot;
  logic [2:0]    pos_bit;
  logic          pos_xbit;

  int nchk = 0, nfail = 0;
  int src_cnt = 0, mdl_k = 0, fcount = 0;
  bit src_on = 1'b1, track_rx = 1'b1, rx_ignore = 1'b0, finished = 1'b0;
  logic [7:0] rx_q[$];

  function automatic logic [7:0] tx_pat(int k);
    return 8'(k * 37 + 11);
  endfunction
  function automatic logic [7:0] rx_pat(int f, int s);
    return 8'(f * 53 + s * 29 + 150);
  endfunction

  assign tx_data  = tx_pat(src_cnt);
  assign tx_valid = src_on;

  tdm_slot_engine dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_sel(sync_sel),
    .lsb_first(lsb_first), .extra_bit(extra_bit), .num_slots(num_slots),
    .sample_pt(sample_pt), .drive_stop(drive_stop), .tx_mask(tx_mask),
    .rx_mask(rx_mask), .bclk(bclk), .fsync0(fsync0), .fsync1(fsync1),
    .din(din), .dout(dout), .dout_en(dout_en), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .err_missed(err_missed),
    .err_extra(err_extra), .err_underrun(err_underrun),
    .err_overflow(err_overflow), .pos_slot(pos_slot), .pos_bit(pos_bit),
    .pos_xbit(pos_xbit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // source side: a byte is taken at the posedge that follows tx_ready && tx_valid
  always begin
    @(negedge clk);
    if (tx_ready && tx_valid) begin
      @(posedge clk);
      #1 src_cnt++;
    end
  end

  // scoreboard monitor for received bytes
  always @(negedge clk) begin
    if (rx_valid && rx_ready && !rx_ignore) begin
      if (rx_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R5 unexpected rx byte actual=%0h expected=none", rx_data);
      end else begin
        check("R4", "rx byte", int'(rx_data), int'(rx_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // one bit time = 16 engine clocks; the check lands 8 clocks after the rise,
  // where the engine count inside the bit is 5
  task automatic do_bit(input bit fs, input bit noise, input bit d, input bit chk,
                        input bit e_en, input bit e_d, input string req);
    @(negedge clk);
    bclk = 1'b1;
    din  = d;
    if (sync_sel) begin fsync1 = fs; fsync0 = noise; end
    else          begin fsync0 = fs; fsync1 = noise; end
    repeat (8) @(negedge clk);
    if (chk) begin
      check(req, "dout_en", int'(dout_en), int'(e_en));
      if (e_en) check("R3", "dout", int'(dout), int'(e_d));
    end
    bclk = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic idle_bits(input int n, input bit sync_first, input string req);
    for (int i = 0; i < n; i++)
      do_bit(sync_first && i == 0, i[0], i[1], 1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic frame(input bit with_sync, input int xsync_at, input bit chk);
    int nsl = int'(num_slots);
    int nbits = nsl * 8 + (extra_bit ? 1 : 0);
    logic [7:0] cur_tx = 8'h00;
    for (int p = 0; p < nbits; p++) begin
      int s = p / 8;
      int b = p % 8;
      bit xb = (p == nsl * 8);
      bit fs = (p == 0 && with_sync) || (p == xsync_at);
      logic [7:0] rb = rx_pat(fcount, s);
      bit d = xb ? 1'b1 : (lsb_first ? rb[b] : rb[7 - b]);
      bit nd, rel, e_en;
      string req;
      if (!xb && b == 7 && rx_mask[s] && track_rx) rx_q.push_back(rb);
      if (!xb && b == 0 && tx_mask[s]) begin
        cur_tx = src_on ? tx_pat(mdl_k) : 8'h00;
        if (src_on) mdl_k++;
      end
      nd   = (s + 1 < nsl) ? tx_mask[s + 1] : (!extra_bit && tx_mask[0]);
      rel  = !xb && b == 7 && drive_stop <= 16'd5 && !nd;
      e_en = !xb && tx_mask[s] && !rel;
      req  = xb ? "R7" : (rel ? "R6" : (!tx_mask[s] ? "R5" : "R3"));
      do_bit(fs, (p % 5) == 2, d, chk, e_en, lsb_first ? cur_tx[b] : cur_tx[7 - b], req);
    end
    fcount++;
  endtask

  task automatic start(input int nsl, input bit lsb, input bit sel, input bit xb,
                       input int ds, input logic [7:0] txm, input logic [7:0] rxm);
    num_slots  = 10'(nsl);
    lsb_first  = lsb;
    sync_sel   = sel;
    extra_bit  = xb;
    drive_stop = 16'(ds);
    tx_mask    = '0;
    rx_mask    = '0;
    tx_mask[7:0] = txm;
    rx_mask[7:0] = rxm;
    @(negedge clk);
    enable = 1'b1;
    mdl_k  = src_cnt;
  endtask

  task automatic stop_engine();
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_errs(input string req, input int m, input int x, input int u, input int o);
    check(req, "err_missed", int'(err_missed), m);
    check(req, "err_extra", int'(err_extra), x);
    check(req, "err_underrun", int'(err_underrun), u);
    check(req, "err_overflow", int'(err_overflow), o);
  endtask

  initial begin
    int saved;
    int fc;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "dout_en at reset", int'(dout_en), 0);
    check("R1", "rx_valid at reset", int'(rx_valid), 0);
    check("R1", "tx_ready at reset", int'(tx_ready), 0);
    check_errs("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2, R3, R4, R5: MSB first, slots 0,1,3 driven, slots 1,2 received
    start(4, 1'b0, 1'b0, 1'b0, 12, 8'b1011, 8'b0110);
    idle_bits(3, 1'b0, "R2");
    check("R2", "no byte before sync", src_cnt, mdl_k);
    repeat (3) frame(1'b1, -1, 1'b1);
    repeat (4) @(negedge clk);
    check("R4", "rx scoreboard drained", rx_q.size(), 0);
    check("R5", "bytes taken", src_cnt, mdl_k);
    check_errs("R7", 0, 0, 0, 0);
    stop_engine();

    // R12, R7, R6: LSB first, second sync input, spare bit, early drive stop
    start(3, 1'b1, 1'b1, 1'b1, 2, 8'b011, 8'b101);
    idle_bits(2, 1'b0, "R2");
    repeat (2) frame(1'b1, -1, 1'b1);
    repeat (4) @(negedge clk);
    check("R12", "rx scoreboard drained", rx_q.size(), 0);
    check_errs("R12", 0, 0, 0, 0);
    stop_engine();

    // R6: drive held across the wrap into a driven slot 0
    start(3, 1'b0, 1'b0, 1'b0, 2, 8'b101, 8'b010);
    idle_bits(2, 1'b0, "R2");
    repeat (2) frame(1'b1, -1, 1'b1);
    repeat (4) @(negedge clk);
    check("R6", "rx scoreboard drained", rx_q.size(), 0);
    check_errs("R6", 0, 0, 0, 0);
    stop_engine();

    // R8: missing sync where driven slot 0 would take a byte
    start(4, 1'b0, 1'b0, 1'b0, 12, 8'b0001, 8'b0010);
    idle_bits(2, 1'b0, "R2");
    frame(1'b1, -1, 1'b1);
    repeat (4) @(negedge clk);
    track_rx = 1'b0; rx_ignore = 1'b1;
    saved = src_cnt;
    frame(1'b0, -1, 1'b0);
    check_errs("R8", 1, 0, 0, 0);
    check("R8", "no byte after missed sync", src_cnt, saved);
    check("R8", "pos_slot", int'(pos_slot), 0);
    check("R8", "pos_bit", int'(pos_bit), 0);
    idle_bits(8, 1'b1, "R8");
    check("R8", "still no byte", src_cnt, saved);
    stop_engine();
    check_errs("R1", 0, 0, 0, 0);

    // R9: extra sync at slot 2 bit 3
    start(4, 1'b0, 1'b0, 1'b0, 12, 8'b0001, 8'b0000);
    idle_bits(2, 1'b0, "R2");
    frame(1'b1, -1, 1'b1);
    frame(1'b1, 19, 1'b0);
    check_errs("R9", 0, 1, 0, 0);
    check("R9", "pos_slot", int'(pos_slot), 2);
    check("R9", "pos_bit", int'(pos_bit), 3);
    saved = src_cnt;
    idle_bits(4, 1'b1, "R9");
    check("R9", "pos_slot held", int'(pos_slot), 2);
    check("R9", "pos_bit held", int'(pos_bit), 3);
    check("R9", "no byte while halted", src_cnt, saved);
    stop_engine();
    track_rx = 1'b1; rx_ignore = 1'b0;

    // R10: source empty, then refilled
    start(4, 1'b0, 1'b0, 1'b0, 12, 8'b0101, 8'b0000);
    idle_bits(2, 1'b0, "R2");
    saved = src_cnt;
    src_on = 1'b0;
    frame(1'b1, -1, 1'b1);
    check("R10", "err_underrun", int'(err_underrun), 1);
    check("R10", "no byte taken", src_cnt, saved);
    src_on = 1'b1;
    frame(1'b1, -1, 1'b1);
    check("R10", "err_underrun sticky", int'(err_underrun), 1);
    check("R10", "bytes taken after refill", src_cnt, mdl_k);
    stop_engine();

    // R11: sink stalled across two delivered slots
    rx_ready = 1'b0; rx_ignore = 1'b1; track_rx = 1'b0;
    start(4, 1'b0, 1'b0, 1'b0, 12, 8'b0000, 8'b0110);
    idle_bits(2, 1'b0, "R2");
    fc = fcount;
    frame(1'b1, -1, 1'b1);
    check("R11", "err_overflow", int'(err_overflow), 1);
    check("R11", "rx_valid held", int'(rx_valid), 1);
    check("R11", "newest byte kept", int'(rx_data), int'(rx_pat(fc, 2)));
    @(negedge clk); rx_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "rx_valid after accept", int'(rx_valid), 0);
    check("R11", "err_overflow sticky", int'(err_overflow), 1);
    stop_engine();
    rx_ignore = 1'b0; track_rx = 1'b1;

    // R1: disabled engine ignores line activity
    check_errs("R1", 0, 0, 0, 0);
    tx_mask = '1; rx_mask = '1;
    saved = src_cnt;
    idle_bits(10, 1'b1, "R1");
    check("R1", "no byte while disabled", src_cnt, saved);
    check("R1", "pos_slot", int'(pos_slot), 0);
    check("R1", "pos_bit", int'(pos_bit), 0);
    check("R1", "pos_xbit", int'(pos_xbit), 0);
    check("R1", "rx_valid", int'(rx_valid), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule